// File: doc/BRIEF.md
# SPI Write-Then-Read Transfer Engine

This block is an SPI master that carries out one serial-flash style transaction per start command. A transaction opens by pulling chip select low. It then shifts out a requested number of bytes taken from a valid/ready byte input. Next it clocks in a requested number of bytes and hands them out on a valid/ready byte output. Chip select rises only once the final received byte has been accepted. Each length is a 24-bit count, and either count may be zero. A phase with a zero count is left out entirely.

The serial clock comes from the system clock divided by the prescale value plus one, and the prescale value is an 8-bit register. The engine works in SPI mode 0 with one data line: the clock idles low, outgoing data changes on the falling edge, incoming data is sampled on the rising edge, and bytes travel most significant bit first. The write-protect and hold pins are tied inactive, which is high. A prescale write that arrives during a transaction is parked and applied once the engine is idle.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, busy_o is 0, tx_ready_o is 0, rx_valid_o is 0 and presc_o is 14.
- R2: In the send phase each byte is shifted out MSB first on mosi_o. Each bit is stable at the rising sclk_o edge and changes only when sclk_o falls. sclk_o idles low.
- R3: In the receive phase miso_i is sampled at each rising sclk_o edge, MSB first. The assembled byte is offered on rx_data_o with rx_valid_o high, and it is held stable with no further sclk_o pulses until rx_ready_i is high.
- R4: The send phase completes before any receive clock. cs_n_o stays low from the start of the transaction through the last receive byte, and returns high once that byte is accepted.
- R5: A phase whose length is zero produces no sclk_o pulses. With both lengths zero, the transaction is one low pulse on cs_n_o and no clock.
- R6: For prescale p ≥ 1 the sclk_o period within a byte is p+1 system cycles. Prescale 0 behaves as 1, which gives a 2-cycle period.
- R7: A prescale write while busy_o is low appears on presc_o in the next cycle. A write while busy_o is high leaves presc_o unchanged until busy_o falls, and then takes effect.
- R8: busy_o is high from the accepted start until cs_n_o is released. A start request while busy_o is high is ignored.
- R9: While the engine waits for a send byte (tx_ready_o high, tx_valid_i low), sclk_o stays low and no bit is shifted.
- R10: wp_n_o and hold_n_o are always 1.
- R11: sclk_o never goes high while cs_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one transaction (taken when idle) |
| send_len_i | input | 24 | Number of bytes to send |
| recv_len_i | input | 24 | Number of bytes to receive |
| busy_o | output | 1 | Transaction in progress |
| presc_wr_i | input | 1 | Prescale write strobe |
| presc_val_i | input | 8 | Prescale value to write |
| presc_o | output | 8 | Prescale value in use |
| tx_valid_i | input | 1 | Send byte available |
| tx_data_i | input | 8 | Send byte |
| tx_ready_o | output | 1 | Engine takes a send byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_data_o | output | 8 | Received byte |
| rx_ready_i | input | 1 | Consumer accepts the received byte |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| wp_n_o | output | 1 | Write protect, held high |
| hold_n_o | output | 1 | Hold, held high |

## Verification
The hardest situation to reach is a prescale write and a second start request that arrive in the middle of a transaction. Either one, if mishandled, changes the clock rate partway through or opens a second chip-select window. The bench starts a short transaction and then, while busy_o is high, pulses both the prescale strobe and start together. It then checks that the clock period, the number of chip-select falls and the number of clock pulses all match a single transaction at the old rate. Finally it checks that the parked prescale value appears only after busy_o drops.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_TX_WAIT,
        ST_TX_BITS,
        ST_RX_BITS,
        ST_RX_HOLD,
        ST_RELEASE
    } xfer_state_e;

endpackage

// File: rtl/spi_presc_reg.sv
module spi_presc_reg #(
    parameter int PRESC_W   = 8,
    parameter int PRESC_RST = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [PRESC_W-1:0] val_i,
    input  logic               idle_i,
    output logic [PRESC_W-1:0] presc_o
);

    logic [PRESC_W-1:0] presc_d, presc_q;
    logic [PRESC_W-1:0] park_d, park_q;
    logic               pend_d, pend_q;

    always_comb begin
        presc_d = presc_q;
        park_d  = park_q;
        pend_d  = pend_q;
        if (wr_i) begin
            if (idle_i) begin
                presc_d = val_i;
                pend_d  = 1'b0;
            end else begin
                park_d  = val_i;
                pend_d  = 1'b1;
            end
        end else if (pend_q && idle_i) begin
            presc_d = park_q;
            pend_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= PRESC_W'(PRESC_RST);
            park_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            presc_q <= presc_d;
            park_q  <= park_d;
            pend_q  <= pend_d;
        end
    end

    assign presc_o = presc_q;

endmodule

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               sclk_o,
    output logic               sample_o,
    output logic               end_o
);

    localparam int CW = PRESC_W + 1;

    logic [CW-1:0] div;
    logic [CW-1:0] lo_len;
    logic [CW-1:0] cnt_d, cnt_q;

    // Divisor of at least two so that a clock pulse always has a high and a low half.
    assign div    = (presc_i == '0) ? CW'(2) : CW'(presc_i) + CW'(1);
    assign lo_len = div - (div >> 1);

    assign sclk_o   = run_i && (cnt_q >= lo_len);
    assign sample_o = run_i && (cnt_q == lo_len - CW'(1));
    assign end_o    = run_i && (cnt_q == div - CW'(1));

    always_comb begin
        if (!run_i || end_o) cnt_d = '0;
        else                 cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int LEN_W     = 24,
    parameter int DATA_W    = 8,
    parameter int PRESC_W   = 8,
    parameter int PRESC_RST = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   send_len_i,
    input  logic [LEN_W-1:0]   recv_len_i,
    output logic               busy_o,
    input  logic               presc_wr_i,
    input  logic [PRESC_W-1:0] presc_val_i,
    output logic [PRESC_W-1:0] presc_o,
    input  logic               tx_valid_i,
    input  logic [DATA_W-1:0]  tx_data_i,
    output logic               tx_ready_o,
    output logic               rx_valid_o,
    output logic [DATA_W-1:0]  rx_data_o,
    input  logic               rx_ready_i,
    output logic               sclk_o,
    output logic               cs_n_o,
    output logic               mosi_o,
    input  logic               miso_i,
    output logic               wp_n_o,
    output logic               hold_n_o
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        xfer_state_e       st;
        logic              cs_n;
        logic [LEN_W-1:0]  slen;
        logic [LEN_W-1:0]  rlen;
        logic [BIT_W-1:0]  bidx;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx_data;
    } regs_t;

    regs_t r_d, r_q;

    logic t_run, t_sample, t_end, idle;

    assign idle  = (r_q.st == ST_IDLE);
    assign t_run = (r_q.st == ST_TX_BITS) || (r_q.st == ST_RX_BITS);

    spi_presc_reg #(
        .PRESC_W   (PRESC_W),
        .PRESC_RST (PRESC_RST)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (presc_wr_i),
        .val_i   (presc_val_i),
        .idle_i  (idle),
        .presc_o (presc_o)
    );

    spi_bit_timer #(
        .PRESC_W (PRESC_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (t_run),
        .presc_i  (presc_o),
        .sclk_o   (sclk_o),
        .sample_o (t_sample),
        .end_o    (t_end)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.slen = send_len_i;
                    r_d.rlen = recv_len_i;
                    r_d.cs_n = 1'b0;
                    r_d.st   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                r_d.bidx = '0;
                if (r_q.slen != '0)      r_d.st = ST_TX_WAIT;
                else if (r_q.rlen != '0) r_d.st = ST_RX_BITS;
                else                     r_d.st = ST_RELEASE;
            end
            ST_TX_WAIT: begin
                if (tx_valid_i) begin
                    r_d.tx_sh = tx_data_i;
                    r_d.bidx  = '0;
                    r_d.st    = ST_TX_BITS;
                end
            end
            ST_TX_BITS: begin
                if (t_end) begin
                    if (r_q.bidx == LAST_BIT) begin
                        r_d.slen = r_q.slen - LEN_W'(1);
                        r_d.bidx = '0;
                        if (r_q.slen != LEN_W'(1)) r_d.st = ST_TX_WAIT;
                        else if (r_q.rlen != '0)   r_d.st = ST_RX_BITS;
                        else                       r_d.st = ST_RELEASE;
                    end else begin
                        r_d.bidx  = r_q.bidx + BIT_W'(1);
                        r_d.tx_sh = {r_q.tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
            end
            ST_RX_BITS: begin
                if (t_sample) r_d.rx_sh = {r_q.rx_sh[DATA_W-2:0], miso_i};
                if (t_end) begin
                    if (r_q.bidx == LAST_BIT) begin
                        r_d.rx_data = r_q.rx_sh;
                        r_d.st      = ST_RX_HOLD;
                    end else begin
                        r_d.bidx = r_q.bidx + BIT_W'(1);
                    end
                end
            end
            ST_RX_HOLD: begin
                if (rx_ready_i) begin
                    r_d.rlen = r_q.rlen - LEN_W'(1);
                    r_d.bidx = '0;
                    r_d.st   = (r_q.rlen == LEN_W'(1)) ? ST_RELEASE : ST_RX_BITS;
                end
            end
            ST_RELEASE: begin
                r_d.cs_n = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = !idle;
    assign cs_n_o     = r_q.cs_n;
    assign tx_ready_o = (r_q.st == ST_TX_WAIT);
    assign rx_valid_o = (r_q.st == ST_RX_HOLD);
    assign rx_data_o  = r_q.rx_data;
    assign mosi_o     = (r_q.st == ST_TX_BITS) ? r_q.tx_sh[DATA_W-1] : 1'b0;
    assign wp_n_o     = 1'b1;
    assign hold_n_o   = 1'b1;

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
    parameter int DATA_W  = 8,
    parameter int PRESC_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy_o,
    input logic               cs_n_o,
    input logic               sclk_o,
    input logic               wp_n_o,
    input logic               hold_n_o,
    input logic [PRESC_W-1:0] presc_o,
    input logic               rx_valid_o,
    input logic               rx_ready_i,
    input logic [DATA_W-1:0]  rx_data_o,
    input logic               tx_ready_o,
    input logic               tx_valid_i
);

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o); // R4

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o); // R11

    AST_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wp_n_o && hold_n_o); // R10

    AST_PRESC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(presc_o)); // R7

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o) && !sclk_o)); // R3

    AST_TX_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready_o && !tx_valid_i) |=> !sclk_o); // R9

    AST_NO_RX_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> !rx_valid_o); // R4

endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(
    .DATA_W  (DATA_W),
    .PRESC_W (PRESC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .wp_n_o     (wp_n_o),
    .hold_n_o   (hold_n_o),
    .presc_o    (presc_o),
    .rx_valid_o (rx_valid_o),
    .rx_ready_i (rx_ready_i),
    .rx_data_o  (rx_data_o),
    .tx_ready_o (tx_ready_o),
    .tx_valid_i (tx_valid_i)
);

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] send_len_i = '0;
    logic [23:0] recv_len_i = '0;
    logic        busy_o;
    logic        presc_wr_i = 1'b0;
    logic [7:0]  presc_val_i = '0;
    logic [7:0]  presc_o;
    logic        tx_valid_i = 1'b0;
    logic [7:0]  tx_data_i = '0;
    logic        tx_ready_o;
    logic        rx_valid_o;
    logic [7:0]  rx_data_o;
    logic        rx_ready_i = 1'b0;
    logic        sclk_o, cs_n_o, mosi_o, miso_i, wp_n_o, hold_n_o;

    always #4 clk = ~clk;

    spi_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .send_len_i(send_len_i),
        .recv_len_i(recv_len_i), .busy_o(busy_o), .presc_wr_i(presc_wr_i),
        .presc_val_i(presc_val_i), .presc_o(presc_o), .tx_valid_i(tx_valid_i),
        .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o),
        .rx_data_o(rx_data_o), .rx_ready_i(rx_ready_i), .sclk_o(sclk_o),
        .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i), .wp_n_o(wp_n_o),
        .hold_n_o(hold_n_o)
    );

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Slave model and bus monitor, updated away from the active edge.
    logic        mon_clr = 1'b0;
    logic [63:0] pat_load = '0;
    int          mon_slen = 0;
    logic [63:0] miso_pat = '0;
    int          rise_cnt = 0;
    int          bad_rise = 0;
    int          cs_falls = 0;
    int          per_min = 0;
    int          per_max = 0;
    int          last_rise = 0;
    logic        sclk_prev = 1'b0;
    logic        cs_prev = 1'b1;
    logic [7:0]  mosi_bytes [0:7];

    assign miso_i = miso_pat[63];

    always @(negedge clk) begin
        if (mon_clr) begin
            miso_pat = pat_load;
            rise_cnt = 0;
            bad_rise = 0;
            cs_falls = 0;
            per_min  = 99999;
            per_max  = 0;
            for (int i = 0; i < 8; i++) mosi_bytes[i] = '0;
        end else begin
            if (sclk_o && !sclk_prev) begin
                if (cs_n_o) bad_rise = bad_rise + 1;
                if (rise_cnt / 8 < 8)
                    mosi_bytes[rise_cnt / 8] = {mosi_bytes[rise_cnt / 8][6:0], mosi_o};
                if (rise_cnt % 8 != 0) begin
                    if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                    if (cyc - last_rise > per_max) per_max = cyc - last_rise;
                end
                last_rise = cyc;
                if (rise_cnt >= mon_slen * 8) miso_pat = {miso_pat[62:0], 1'b0};
                rise_cnt = rise_cnt + 1;
            end
            if (!cs_n_o && cs_prev) cs_falls = cs_falls + 1;
        end
        sclk_prev = sclk_o;
        cs_prev   = cs_n_o;
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
            $display("%0d/%0d checks passed", total - fails, total + 1);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total = total + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mon_clear(input int sl, input logic [63:0] pat);
        pat_load = pat;
        mon_slen = sl;
        mon_clr  = 1'b1;
        @(negedge clk);
        #1 mon_clr = 1'b0;
    endtask

    task automatic do_start(input int sl, input int rl);
        @(negedge clk);
        start_i    = 1'b1;
        send_len_i = 24'(sl);
        recv_len_i = 24'(rl);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        tx_valid_i = 1'b1;
        tx_data_i  = b;
        while (!tx_ready_o) @(negedge clk);
        @(negedge clk);
        tx_valid_i = 1'b0;
    endtask

    task automatic recv_byte(input string req, input int hold, output logic [7:0] b);
        logic [7:0] d0;
        int r0;
        while (!rx_valid_o) @(negedge clk);
        check("R4", "cs_n low while receive byte pending", cs_n_o, 0);
        if (hold > 0) begin
            d0 = rx_data_o;
            r0 = rise_cnt;
            repeat (hold) @(negedge clk);
            check(req, "rx_valid held under back-pressure", rx_valid_o, 1);
            check(req, "rx_data stable under back-pressure", rx_data_o, d0);
            check(req, "no clock under back-pressure", rise_cnt, r0);
        end
        b = rx_data_o;
        rx_ready_i = 1'b1;
        @(negedge clk);
        rx_ready_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic write_presc(input logic [7:0] v);
        @(negedge clk);
        presc_wr_i  = 1'b1;
        presc_val_i = v;
        @(negedge clk);
        presc_wr_i = 1'b0;
    endtask

    task automatic run_xfer(input string req, input int sl, input int rl,
                            input logic [63:0] txw, input logic [63:0] pat,
                            input int stall, input int hold);
        logic [7:0] b;
        mon_clear(sl, pat);
        do_start(sl, rl);
        check("R8", "busy after start", busy_o, 1);
        for (int i = 0; i < sl; i++) begin
            if (i == 0 && stall > 0) begin
                repeat (stall) @(negedge clk);
                check("R9", "no clock while send byte missing", rise_cnt, 0);
                check("R9", "sclk low while stalled", sclk_o, 0);
            end
            send_byte(txw[63 - 8 * i -: 8]);
        end
        for (int i = 0; i < rl; i++) begin
            recv_byte(req, hold, b);
            check("R3", "received byte", b, pat[63 - 8 * i -: 8]);
        end
        wait_idle();
        check("R4", "cs_n high after transaction", cs_n_o, 1);
        check(req, "clock pulse count", rise_cnt, 8 * (sl + rl));
        check("R11", "clock pulses with cs_n high", bad_rise, 0);
        check("R8", "single chip-select window", cs_falls, 1);
        for (int i = 0; i < sl; i++)
            check("R2", "sent byte on mosi", mosi_bytes[i], txw[63 - 8 * i -: 8]);
    endtask

    task automatic t_reset();
        check("R1", "cs_n after reset", cs_n_o, 1);
        check("R1", "sclk after reset", sclk_o, 0);
        check("R1", "busy after reset", busy_o, 0);
        check("R1", "tx_ready after reset", tx_ready_o, 0);
        check("R1", "rx_valid after reset", rx_valid_o, 0);
        check("R1", "prescale after reset", presc_o, 14);
        check("R10", "wp_n and hold_n", {wp_n_o, hold_n_o}, 2'b11);
    endtask

    task automatic t_default_rate();
        run_xfer("R2", 2, 2, 64'hA53C_0000_0000_0000, 64'h96F0_0000_0000_0000, 0, 0);
        check("R6", "min period at prescale 14", per_min, 15);
        check("R6", "max period at prescale 14", per_max, 15);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] b;
        mon_clear(1, 64'h5A00_0000_0000_0000);
        do_start(1, 1);
        @(negedge clk);
        presc_wr_i  = 1'b1;
        presc_val_i = 8'd3;
        start_i     = 1'b1;
        send_len_i  = 24'd2;
        recv_len_i  = 24'd2;
        @(negedge clk);
        presc_wr_i = 1'b0;
        start_i    = 1'b0;
        check("R7", "prescale unchanged while busy", presc_o, 14);
        send_byte(8'hC3);
        recv_byte("R3", 0, b);
        check("R3", "received byte", b, 8'h5A);
        check("R7", "prescale still unchanged before release", presc_o, 14);
        wait_idle();
        check("R8", "second start ignored: one cs window", cs_falls, 1);
        check("R8", "second start ignored: pulse count", rise_cnt, 16);
        check("R6", "rate kept during transaction", per_max, 15);
        @(negedge clk);
        check("R7", "parked prescale applied after idle", presc_o, 3);
    endtask

    task automatic t_fast_rate();
        write_presc(8'd1);
        check("R7", "idle prescale write", presc_o, 1);
        run_xfer("R2", 1, 1, 64'h8100_0000_0000_0000, 64'h7E00_0000_0000_0000, 0, 0);
        check("R6", "period at prescale 1", per_max, 2);
        check("R6", "min period at prescale 1", per_min, 2);
    endtask

    task automatic t_zero_lengths();
        run_xfer("R5", 0, 1, 64'h0, 64'hE100_0000_0000_0000, 0, 0);
        run_xfer("R5", 1, 0, 64'h3700_0000_0000_0000, 64'h0, 0, 0);
        run_xfer("R5", 0, 0, 64'h0, 64'h0, 0, 0);
    endtask

    task automatic t_stall_and_hold();
        run_xfer("R9", 2, 1, 64'h0FF0_0000_0000_0000, 64'hC600_0000_0000_0000, 20, 0);
        run_xfer("R3", 1, 2, 64'h4400_0000_0000_0000, 64'h1BE2_0000_0000_0000, 0, 12);
    endtask

    task automatic t_prescale_zero();
        write_presc(8'd0);
        check("R7", "idle prescale write of zero", presc_o, 0);
        run_xfer("R6", 1, 1, 64'h6900_0000_0000_0000, 64'hB200_0000_0000_0000, 0, 0);
        check("R6", "prescale 0 behaves as 1", per_max, 2);
        write_presc(8'd4);
        run_xfer("R6", 1, 0, 64'hD200_0000_0000_0000, 64'h0, 0, 0);
        check("R6", "odd divisor period at prescale 4", per_max, 5);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mosi_bytes[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_rate();
        t_busy_ignore();
        t_fast_rate();
        t_zero_lengths();
        t_stall_and_hold();
        t_prescale_zero();
        check("R10", "wp_n and hold_n at end", {wp_n_o, hold_n_o}, 2'b11);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule